// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block computes the architectural state change that a 32-bit processor core makes in the cycle it enters an exception or interrupt handler. Each cycle it looks at the pending exception causes, the external interrupt line and the current interrupt-enable bits. It picks one cause by fixed priority and produces, one clock later, the redirected program counter. It also produces a write strobe and data for one of two saved-address registers, and the next value of the interrupt-enable register.

Two classes of cause exist. Ordinary causes (bus errors, divide by zero, system call, external interrupt) save the PC into the exception-address register and stash the global enable in the exception saved-enable bit. Debug causes (breakpoint, watchpoint) use the breakpoint-address register and the breakpoint saved-enable bit instead. Handlers sit in 32-byte slots above a 256-byte aligned base. Ordinary causes use the normal base unless a remap control sends them to the debug base. A system call can instead be serviced by a bypass path that just steps the PC forward by one instruction.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several causes are pending in one cycle, the cause reported on `cause_o` is chosen in this order, highest first: instruction bus error, data bus error, breakpoint, watchpoint, divide by zero, system call, interrupt. Cause codes are: 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call.
- R2: An ordinary cause that is not bypassed pulses `ea_we_o` for one cycle with `save_addr_o` equal to the PC presented with the request, and leaves `ba_we_o` low.
- R3: On an ordinary cause that is not bypassed, the enable bits (bit 0 global enable, bit 1 exception saved-enable, bit 2 breakpoint saved-enable) become: bit 1 set if bit 0 or bit 1 was set, bit 0 cleared, bit 2 unchanged.
- R4: For an ordinary cause, the new PC is {base[31:8], code, 5'b00000}, where base is `eba_i` when `remap_i` is 0 and `deba_i` when it is 1.
- R5: A debug cause pulses `ba_we_o` with the request PC and leaves `ea_we_o` low. It sets bit 2 if bit 0 was set, clears bit 0, leaves bit 1 unchanged, and vectors to {deba_i[31:8], code, 5'b00000} whatever `remap_i` is.
- R6: The interrupt line is taken only when `irq_i` is 1 and enable bit 0 is 1; otherwise it causes no redirect.
- R7: A selected system call with `scall_bypass_i` high redirects to PC+4, writes neither saved-address register and leaves the enable bits unchanged.
- R8: With no cause taken, `redirect_o`, `ea_we_o` and `ba_we_o` are low, `pc_o` equals the presented PC and `ie_o` equals the presented enable bits, one cycle later.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ibus_i | input | 1 | Instruction bus error pending |
| req_dbus_i | input | 1 | Data bus error pending |
| req_brk_i | input | 1 | Breakpoint pending |
| req_wp_i | input | 1 | Watchpoint pending |
| req_div_i | input | 1 | Divide by zero pending |
| req_scall_i | input | 1 | System call pending |
| scall_bypass_i | input | 1 | System call is serviced by the bypass path |
| irq_i | input | 1 | External interrupt line |
| remap_i | input | 1 | Send ordinary causes to the debug base |
| pc_i | input | 32 | Current program counter |
| eba_i | input | 32 | Normal exception base (bits 7:0 ignored) |
| deba_i | input | 32 | Debug exception base (bits 7:0 ignored) |
| ie_i | input | 3 | Current enable bits {saved-bp, saved-exc, global} |
| redirect_o | output | 1 | PC is being redirected this cycle |
| cause_o | output | 3 | Code of the cause taken |
| pc_o | output | 32 | New program counter |
| ea_we_o | output | 1 | Write exception-address register |
| ba_we_o | output | 1 | Write breakpoint-address register |
| save_addr_o | output | 32 | Value to write into the selected address register |
| ie_o | output | 3 | Next enable bits |

## Verification
The hardest situations are the simultaneous ones: an interrupt arriving with the global enable clear while another cause is also pending, and a bypassed system call that loses to a higher-priority cause, where the bypass must not apply. Random stimulus gives each cause a low, independent probability and randomises the enable bits and the bypass and remap controls, so stacked requests in all combinations appear often. Directed cases force the all-pending, masked-interrupt and bypass-versus-bus-error collisions explicitly.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        C_NONE  = 3'd0,
        C_BRK   = 3'd1,
        C_IBUS  = 3'd2,
        C_WP    = 3'd3,
        C_DBUS  = 3'd4,
        C_DIV   = 3'd5,
        C_IRQ   = 3'd6,
        C_SCALL = 3'd7
    } cause_e;

    localparam int CAUSE_W  = 3;
    localparam int N_CAUSES = 7;
    localparam int IE_W     = 3;
    localparam int IE_GLB   = 0;
    localparam int IE_EXC   = 1;
    localparam int IE_DBG   = 2;

    // Priority rank (0 = highest) to cause code.
    function automatic cause_e rank_to_cause(input int rank);
        case (rank)
            0:       return C_IBUS;
            1:       return C_DBUS;
            2:       return C_BRK;
            3:       return C_WP;
            4:       return C_DIV;
            5:       return C_SCALL;
            6:       return C_IRQ;
            default: return C_NONE;
        endcase
    endfunction

    function automatic logic is_debug(input cause_e c);
        return (c == C_BRK) || (c == C_WP);
    endfunction

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_entry_pkg::*;
#(
    parameter int N = N_CAUSES
) (
    input  logic [N-1:0] pend_i,   // bit 0 = highest priority
    output logic         hit_o,
    output cause_e       cause_o
);

    always_comb begin
        hit_o   = 1'b0;
        cause_o = C_NONE;
        // Walk from lowest to highest priority so the highest wins last.
        for (int k = N - 1; k >= 0; k--) begin
            if (pend_i[k]) begin
                hit_o   = 1'b1;
                cause_o = rank_to_cause(k);
            end
        end
    end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
    parameter int XLEN   = 32,
    parameter int ALIGN  = 8,
    parameter int SLOT   = 5,
    parameter int CW     = 3
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [CW-1:0]   idx_i,
    output logic [XLEN-1:0] vec_o
);

    localparam int OFS_W = CW + SLOT;

    generate
        if (OFS_W == ALIGN) begin : g_concat
            assign vec_o = {base_i[XLEN-1:ALIGN], idx_i, {SLOT{1'b0}}};
        end else begin : g_add
            logic [XLEN-1:0] ofs;
            assign ofs   = XLEN'({idx_i, {SLOT{1'b0}}});
            assign vec_o = {base_i[XLEN-1:ALIGN], {ALIGN{1'b0}}} + ofs;
        end
    endgenerate

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int ALIGN = 8,
    parameter int SLOT  = 5,
    parameter int ISTEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_ibus_i,
    input  logic            req_dbus_i,
    input  logic            req_brk_i,
    input  logic            req_wp_i,
    input  logic            req_div_i,
    input  logic            req_scall_i,
    input  logic            scall_bypass_i,
    input  logic            irq_i,
    input  logic            remap_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] eba_i,
    input  logic [XLEN-1:0] deba_i,
    input  logic [IE_W-1:0] ie_i,
    output logic            redirect_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [XLEN-1:0] pc_o,
    output logic            ea_we_o,
    output logic            ba_we_o,
    output logic [XLEN-1:0] save_addr_o,
    output logic [IE_W-1:0] ie_o
);

    typedef struct packed {
        logic            redirect;
        cause_e          cause;
        logic [XLEN-1:0] pc;
        logic            ea_we;
        logic            ba_we;
        logic [XLEN-1:0] save_addr;
        logic [IE_W-1:0] ie;
    } entry_t;

    entry_t st_d, st_q;

    logic [N_CAUSES-1:0] pend;
    logic                hit;
    cause_e              sel;
    logic [XLEN-1:0]     base_sel;
    logic [XLEN-1:0]     vec;

    assign pend = {irq_i & ie_i[IE_GLB], req_scall_i, req_div_i,
                   req_wp_i, req_brk_i, req_dbus_i, req_ibus_i};

    exc_cause_sel #(.N(N_CAUSES)) u_sel (
        .pend_i  (pend),
        .hit_o   (hit),
        .cause_o (sel)
    );

    assign base_sel = (is_debug(sel) || remap_i) ? deba_i : eba_i;

    exc_vec_gen #(
        .XLEN  (XLEN),
        .ALIGN (ALIGN),
        .SLOT  (SLOT),
        .CW    (CAUSE_W)
    ) u_vec (
        .base_i (base_sel),
        .idx_i  (sel),
        .vec_o  (vec)
    );

    always_comb begin
        st_d           = '0;
        st_d.cause     = C_NONE;
        st_d.pc        = pc_i;
        st_d.save_addr = pc_i;
        st_d.ie        = ie_i;
        if (hit) begin
            st_d.redirect = 1'b1;
            st_d.cause    = sel;
            if (sel == C_SCALL && scall_bypass_i) begin
                st_d.pc = pc_i + XLEN'(ISTEP);
            end else if (is_debug(sel)) begin
                st_d.ba_we          = 1'b1;
                st_d.ie[IE_DBG]     = ie_i[IE_DBG] | ie_i[IE_GLB];
                st_d.ie[IE_GLB]     = 1'b0;
                st_d.pc             = vec;
            end else begin
                st_d.ea_we          = 1'b1;
                st_d.ie[IE_EXC]     = ie_i[IE_EXC] | ie_i[IE_GLB];
                st_d.ie[IE_GLB]     = 1'b0;
                st_d.pc             = vec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o  = st_q.redirect;
    assign cause_o     = st_q.cause;
    assign pc_o        = st_q.pc;
    assign ea_we_o     = st_q.ea_we;
    assign ba_we_o     = st_q.ba_we;
    assign save_addr_o = st_q.save_addr;
    assign ie_o        = st_q.ie;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN  = 32,
    parameter int ALIGN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ibus_i,
    input logic            req_dbus_i,
    input logic            req_brk_i,
    input logic            req_wp_i,
    input logic            req_div_i,
    input logic            req_scall_i,
    input logic            irq_i,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] deba_i,
    input logic [2:0]      ie_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] pc_o,
    input logic            ea_we_o,
    input logic            ba_we_o,
    input logic [XLEN-1:0] save_addr_o,
    input logic [2:0]      ie_o
);

    logic other_req;
    assign other_req = req_ibus_i | req_dbus_i | req_brk_i | req_wp_i |
                       req_div_i | req_scall_i;

    p_one_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ea_we_o, ba_we_o}));

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !ie_i[0] && !other_req) |=> !redirect_o);

    p_save_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ibus_i || req_dbus_i) |=> (ea_we_o && save_addr_o == $past(pc_i)));

    p_eie_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ibus_i |=> (!ie_o[0] && ie_o[1] == ($past(ie_i[1]) | $past(ie_i[0]))));

    p_debug_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_brk_i && !req_ibus_i && !req_dbus_i)
            |=> (ba_we_o && pc_o[XLEN-1:ALIGN] == $past(deba_i[XLEN-1:ALIGN])));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .ALIGN(ALIGN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ibus_i  (req_ibus_i),
    .req_dbus_i  (req_dbus_i),
    .req_brk_i   (req_brk_i),
    .req_wp_i    (req_wp_i),
    .req_div_i   (req_div_i),
    .req_scall_i (req_scall_i),
    .irq_i       (irq_i),
    .pc_i        (pc_i),
    .deba_i      (deba_i),
    .ie_i        (ie_i),
    .redirect_o  (redirect_o),
    .pc_o        (pc_o),
    .ea_we_o     (ea_we_o),
    .ba_we_o     (ba_we_o),
    .save_addr_o (save_addr_o),
    .ie_o        (ie_o)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_ibus, req_dbus, req_brk, req_wp, req_div, req_scall;
    logic        bypass, irq, remap;
    logic [31:0] pc, eba, deba;
    logic [2:0]  ie;
    logic        redirect_o, ea_we_o, ba_we_o;
    logic [2:0]  cause_o, ie_o;
    logic [31:0] pc_o, save_addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_ibus_i(req_ibus), .req_dbus_i(req_dbus), .req_brk_i(req_brk),
        .req_wp_i(req_wp), .req_div_i(req_div), .req_scall_i(req_scall),
        .scall_bypass_i(bypass), .irq_i(irq), .remap_i(remap),
        .pc_i(pc), .eba_i(eba), .deba_i(deba), .ie_i(ie),
        .redirect_o(redirect_o), .cause_o(cause_o), .pc_o(pc_o),
        .ea_we_o(ea_we_o), .ba_we_o(ba_we_o), .save_addr_o(save_addr_o),
        .ie_o(ie_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected cause code from the priority list in R1 (0 = none).
    function automatic logic [2:0] exp_cause();
        if (req_ibus)        return 3'd2;
        if (req_dbus)        return 3'd4;
        if (req_brk)         return 3'd1;
        if (req_wp)          return 3'd3;
        if (req_div)         return 3'd5;
        if (req_scall)       return 3'd7;
        if (irq && ie[0])    return 3'd6;
        return 3'd0;
    endfunction

    task automatic step_and_check();
        logic [2:0]  c;
        logic        dbg, byp, xr, xea, xba;
        logic [31:0] xpc, base;
        logic [2:0]  xie;
        string       tag;
        c   = exp_cause();
        dbg = (c == 3'd1) || (c == 3'd3);
        byp = (c == 3'd7) && bypass;
        xr  = (c != 3'd0);
        xea = xr && !dbg && !byp;
        xba = xr && dbg;
        base = (dbg || remap) ? deba : eba;
        xie = ie;
        if (!xr) begin
            xpc = pc; tag = "R8";
        end else if (byp) begin
            xpc = pc + 32'd4; tag = "R7";
        end else begin
            xpc = {base[31:8], c, 5'd0};
            tag = dbg ? "R5" : "R4";
            if (dbg) xie[2] = ie[2] | ie[0];
            else     xie[1] = ie[1] | ie[0];
            xie[0] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(cause_o == c, (irq && !ie[0] && c == 3'd0) ? "R6" : "R1", "cause",
            32'(cause_o), 32'(c));
        chk(redirect_o == xr, xr ? "R1" : "R8", "redirect", 32'(redirect_o), 32'(xr));
        chk(pc_o == xpc, tag, "pc", pc_o, xpc);
        chk(ea_we_o == xea, "R2", "ea_we", 32'(ea_we_o), 32'(xea));
        chk(ba_we_o == xba, "R5", "ba_we", 32'(ba_we_o), 32'(xba));
        if (xea || xba)
            chk(save_addr_o == pc, "R2", "save_addr", save_addr_o, pc);
        chk(ie_o == xie, dbg ? "R5" : (byp ? "R7" : "R3"), "ie",
            32'(ie_o), 32'(xie));
    endtask

    task automatic set_req(input logic [6:0] r, input logic b, input logic rm,
                           input logic [2:0] e);
        {irq, req_scall, req_div, req_wp, req_brk, req_dbus, req_ibus} = r;
        bypass = b; remap = rm; ie = e;
    endtask

    initial begin
        set_req(7'd0, 1'b0, 1'b0, 3'd0);
        pc = 32'h0000_1000; eba = 32'h1000_0000; deba = 32'h2000_0000;
        repeat (3) @(negedge clk);
        // R9: outputs zero in reset
        chk({redirect_o, ea_we_o, ba_we_o} == 3'b0 && pc_o == 0 && save_addr_o == 0
            && ie_o == 0 && cause_o == 0, "R9", "reset outputs",
            pc_o, 32'd0);
        rst_n = 1'b1;
        // Directed corner cases
        set_req(7'b1000000, 1'b0, 1'b0, 3'b000); step_and_check(); // R6 masked irq
        set_req(7'b1000000, 1'b0, 1'b0, 3'b001); step_and_check(); // R6 taken irq
        set_req(7'b1111111, 1'b1, 1'b1, 3'b001); step_and_check(); // R1 all pending
        set_req(7'b0000110, 1'b0, 1'b0, 3'b011); step_and_check(); // R1 dbus over brk
        set_req(7'b0001100, 1'b0, 1'b1, 3'b001); step_and_check(); // R5 brk, remap ignored
        set_req(7'b0001000, 1'b0, 1'b0, 3'b000); step_and_check(); // R5 wp, ie clear
        set_req(7'b0100000, 1'b1, 1'b0, 3'b101); step_and_check(); // R7 bypass
        set_req(7'b0100001, 1'b1, 1'b0, 3'b001); step_and_check(); // R7 loses to ibus
        set_req(7'b0100000, 1'b0, 1'b0, 3'b001); step_and_check(); // R2 scall saved
        set_req(7'b0010000, 1'b0, 1'b1, 3'b001); step_and_check(); // R4 remap
        set_req(7'b0000000, 1'b1, 1'b1, 3'b111); step_and_check(); // R8 idle
        // Constrained random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] r;
            for (int j = 0; j < 7; j++) r[j] = ($urandom_range(0, 5) == 0);
            set_req(r, 1'($urandom), 1'($urandom), 3'($urandom));
            pc   = $urandom & 32'hFFFF_FFFC;
            eba  = $urandom;
            deba = $urandom;
            step_and_check();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule